// File: doc/BRIEF.md
# Split-Byte Conversion Result Holding Register

This block keeps one converted analog sample per channel and lets a processor with an 8-bit data path read it as two bytes. The high byte returns the upper eight result bits. The low byte returns the two least significant result bits in its top positions, followed by four constant-zero bits, an overrun flag and a result-ready flag. The block captures the result on a single-cycle valid strobe. It records which of the two bytes have been read since that capture. If a fresh result arrives before both bytes of the previous one were read, the block raises the overrun flag.

Reads are strobes, one for each byte address. The read data is combinational in the default build, so it appears in the same cycle as the strobe. When no strobe is active the read data is all zeros, which lets several channel instances share one OR-combined bus behind a common address decoder. A parameter can add one register stage to the read path. Both status flags clear as a side effect of reading the low byte. The clear takes effect at the clock edge that ends the read cycle, so the data returned during that read still shows the flags before they clear.

Top module: `adc_result_reg`

## Requirements
- R1: A high-byte read returns result bits 9 down to 2. A low-byte read returns result bits 1 and 0 in bit positions 7 and 6.
- R2: Bit 0 of the low byte is the result-ready flag. It is 1 in every cycle after a capture until it is cleared.
- R3: A low-byte read without a capture in the same cycle clears the result-ready flag at the closing clock edge of that cycle. The data returned by that read still shows the flag before the clear.
- R4: Bit 1 of the low byte is the overrun flag. It is set by a capture that arrives when the low byte, the high byte, or both have not been read since the previous capture. A read in the same cycle as the capture does not count toward that previous result.
- R5: A low-byte read clears the overrun flag at the closing edge of the read cycle, unless that same edge sets it again through R4.
- R6: Bits 5 down to 2 of the low byte always read as 0.
- R7: After reset every returned bit is 0. Both bytes count as already read, so the first capture after reset cannot raise overrun.
- R8: When a capture and a low-byte read occur in the same cycle, the read returns the old contents. The new result is kept and the result-ready flag ends at 1.
- R9: With no read strobe active the read data is 0. With both strobes active the low byte is returned.
- R10: A high-byte read alone changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Single-cycle strobe: a new conversion result is present |
| cap_data | input | 10 | Conversion result captured when cap_valid is high |
| rd_lo | input | 1 | Read strobe for the low (status) byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| rd_data | output | 8 | Read data, zero when no strobe is active |

## Verification
Read data is due in the same cycle as its strobe. The bench therefore drives the strobes just after a falling edge and samples rd_data one nanosecond later, well before the next rising edge. Flag changes caused by a capture or a low-byte read take effect at that rising edge. They are first visible to a read strobe in the following cycle, so every flag check is a separate read one cycle or more after the stimulus. The scoreboard pushes one expected byte per driven cycle, idle cycles included. The monitor pops one entry per cycle, which keeps each expected value tied to the cycle in which it is due.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;

   // status flags kept beside the captured result
   typedef struct packed {
      logic ovr;
      logic ready;
   } adc_rr_flags_t;

   // which byte the current read strobe selects
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_LO   = 2'd1,
      RSEL_HI   = 2'd2
   } adc_rr_sel_e;

   function automatic adc_rr_sel_e decode_sel(input logic lo, input logic hi);
      if (lo)      return RSEL_LO;
      else if (hi) return RSEL_HI;
      else         return RSEL_NONE;
   endfunction

endpackage

// File: rtl/adc_rr_hold.sv
module adc_rr_hold #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_valid,
   input  logic [RES_W-1:0] cap_data,
   input  logic             rd_lo,
   output logic [RES_W-1:0] res_q,
   output logic             ready_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         ready_q <= 1'b0;
      end else if (cap_valid) begin
         res_q   <= cap_data;
         ready_q <= 1'b1;          // capture wins over a same-cycle clear (R8)
      end else if (rd_lo) begin
         ready_q <= 1'b0;
      end
   end

   // R2 / R8: any capture leaves the ready flag set
   a_r2_ready_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> ready_q);

   // R3: a plain low-byte read drops the ready flag
   a_r3_ready_cleared_by_low_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !cap_valid) |=> !ready_q);

   // R8: stored result only moves on a capture
   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid |=> $stable(res_q));

endmodule

// File: rtl/adc_rr_ovr.sv
module adc_rr_ovr (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_valid,
   input  logic rd_lo,
   input  logic rd_hi,
   output logic ovr_q
);

   // half-read tracking; reset to "both read" so the first capture is clean
   logic lo_seen_q;
   logic hi_seen_q;
   logic unread;
   logic ovr_d;

   assign unread = !(lo_seen_q && hi_seen_q);

   always_comb begin
      ovr_d = ovr_q && !rd_lo;
      if (cap_valid && unread) ovr_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_seen_q <= 1'b1;
         hi_seen_q <= 1'b1;
      end else if (cap_valid) begin
         lo_seen_q <= 1'b0;
         hi_seen_q <= 1'b0;
      end else begin
         if (rd_lo) lo_seen_q <= 1'b1;
         if (rd_hi) hi_seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_q <= 1'b0;
      else        ovr_q <= ovr_d;
   end

   // R4: a capture over a partly read result flags overrun
   a_r4_overrun_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !(lo_seen_q && hi_seen_q)) |=> ovr_q);

   // R5: a low read with no capture clears overrun
   a_r5_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !cap_valid) |=> !ovr_q);

   // R10: a high read alone never changes the flag
   a_r10_high_read_keeps_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !rd_lo && !cap_valid) |=> $stable(ovr_q));

   // R4: a fresh capture always restarts tracking
   a_r4_tracking_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> (!lo_seen_q && !hi_seen_q));

endmodule

// File: rtl/adc_rr_rdport.sv
module adc_rr_rdport
   import adc_rr_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RES_W-1:0]    res_q,
   input  adc_rr_flags_t       flags,
   input  logic                rd_lo,
   input  logic                rd_hi,
   output logic [BYTE_W-1:0]   rd_data
);

   localparam int LO_BITS = RES_W - BYTE_W;
   localparam int PAD_W   = BYTE_W - LO_BITS - 2;

   adc_rr_sel_e       sel;
   logic [BYTE_W-1:0] lo_byte;
   logic [BYTE_W-1:0] hi_byte;
   logic [BYTE_W-1:0] mux_data;

   assign sel     = decode_sel(rd_lo, rd_hi);
   assign lo_byte = {res_q[LO_BITS-1:0], {PAD_W{1'b0}}, flags.ovr, flags.ready};
   assign hi_byte = res_q[RES_W-1:LO_BITS];

   always_comb begin
      unique case (sel)
         RSEL_LO: mux_data = lo_byte;
         RSEL_HI: mux_data = hi_byte;
         default: mux_data = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_reg
         logic [BYTE_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) data_q <= '0;
            else        data_q <= mux_data;
         end
         assign rd_data = data_q;
      end else begin : g_comb
         assign rd_data = mux_data;

         // R9: an idle bus slot returns zero so channels can be OR-combined
         a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_lo && !rd_hi) |-> (rd_data == '0));

         // R6: padding bits of the status byte stay zero
         a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_lo |-> (rd_data[PAD_W+1:2] == '0));
      end
   endgenerate

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
   import adc_rr_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_valid,
   input  logic [RES_W-1:0]  cap_data,
   input  logic              rd_lo,
   input  logic              rd_hi,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int LO_BITS = RES_W - BYTE_W;

   generate
      if (LO_BITS < 1) begin : g_bad_split
         $error("adc_result_reg: RES_W must exceed BYTE_W");
      end
      if (BYTE_W - LO_BITS - 2 < 1) begin : g_bad_pad
         $error("adc_result_reg: low byte needs room for flags and padding");
      end
   endgenerate

   logic [RES_W-1:0] res_q;
   logic             ready_q;
   logic             ovr_q;
   adc_rr_flags_t    flags;

   assign flags = '{ovr: ovr_q, ready: ready_q};

   adc_rr_hold #(.RES_W(RES_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .cap_data  (cap_data),
      .rd_lo     (rd_lo),
      .res_q     (res_q),
      .ready_q   (ready_q)
   );

   adc_rr_ovr u_ovr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .ovr_q     (ovr_q)
   );

   adc_rr_rdport #(
      .RES_W  (RES_W),
      .BYTE_W (BYTE_W),
      .RD_REG (RD_REG)
   ) u_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .res_q   (res_q),
      .flags   (flags),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi),
      .rd_data (rd_data)
   );

   // R10: a lone high read leaves the ready flag alone
   a_r10_high_read_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !rd_lo && !cap_valid) |=> $stable(ready_q));

   // R5 / R4: overrun can only appear through a capture
   a_r4_overrun_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(cap_valid));

endmodule

// File: tb/tb_adc_result_reg.sv
module tb_adc_result_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cap_valid = 1'b0;
   logic [9:0] cap_data = '0;
   logic       rd_lo = 1'b0;
   logic       rd_hi = 1'b0;
   logic [7:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   adc_result_reg dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .cap_data  (cap_data),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .rd_data   (rd_data)
   );

   typedef struct {
      logic [7:0] val;
      string      req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   // reference state built from the requirements
   logic [9:0] m_data = '0;
   logic       m_ready = 1'b0;
   logic       m_ovr = 1'b0;
   logic       m_lo_seen = 1'b1;
   logic       m_hi_seen = 1'b1;

   task automatic step(input logic cap, input logic [9:0] d,
                       input logic lo, input logic hi, input string req);
      exp_t e;
      logic nxt_ovr;
      @(negedge clk);
      cap_valid = cap;
      cap_data  = d;
      rd_lo     = lo;
      rd_hi     = hi;
      if (lo)      e.val = {m_data[1:0], 4'b0000, m_ovr, m_ready};
      else if (hi) e.val = m_data[9:2];
      else         e.val = 8'h00;
      e.req = req;
      q.push_back(e);
      nxt_ovr = (cap && !(m_lo_seen && m_hi_seen)) || (m_ovr && !lo);
      if (cap) begin
         m_data = d; m_ready = 1'b1; m_lo_seen = 1'b0; m_hi_seen = 1'b0;
      end else begin
         if (lo) begin m_ready = 1'b0; m_lo_seen = 1'b1; end
         if (hi) m_hi_seen = 1'b1;
      end
      m_ovr = nxt_ovr;
   endtask

   // monitor: one expected byte per driven cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data !== e.val) begin
               failures++;
               $display("FAIL %s: rd_data actual=%h expected=%h", e.req, rd_data, e.val);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      step(0, 10'h000, 1, 0, "R7 low after reset");
      step(0, 10'h000, 0, 1, "R7 high after reset");
      // first capture: no overrun
      step(1, 10'h2D5, 0, 0, "R9 idle during capture");
      step(0, 10'h000, 0, 1, "R1 high byte 0xB5");
      step(0, 10'h000, 0, 0, "R9 idle zero");
      step(0, 10'h000, 1, 0, "R2 R6 R7 low byte ready no overrun");
      step(0, 10'h000, 1, 0, "R3 ready cleared");
      // two captures with no reads in between
      step(1, 10'h17E, 0, 0, "R9 idle");
      step(1, 10'h3C3, 0, 0, "R9 idle");
      step(0, 10'h000, 0, 1, "R1 R10 high byte second value");
      step(0, 10'h000, 1, 0, "R4 R10 overrun visible after high read");
      step(0, 10'h000, 1, 0, "R5 overrun cleared");
      // only low byte read before next capture
      step(1, 10'h0A1, 0, 0, "R9 idle");
      step(0, 10'h000, 1, 0, "R1 R2 low byte");
      step(1, 10'h155, 0, 0, "R9 idle");
      step(0, 10'h000, 1, 0, "R4 overrun with high unread");
      // both halves read: no overrun
      step(0, 10'h000, 0, 1, "R1 high byte");
      step(1, 10'h2AA, 0, 0, "R9 idle");
      step(0, 10'h000, 0, 1, "R1 high 0xAA");
      step(0, 10'h000, 1, 0, "R4 no overrun after full read");
      // high read in the same cycle as a capture does not count
      step(1, 10'h0FF, 0, 0, "R9 idle");
      step(0, 10'h000, 1, 0, "R1 low of 0x0FF");
      step(1, 10'h301, 0, 1, "R4 high read during capture returns old");
      step(0, 10'h000, 1, 0, "R4 overrun despite same-cycle high read");
      // capture and low read in the same cycle
      step(0, 10'h000, 0, 1, "R1 high byte");
      step(1, 10'h1C2, 1, 0, "R8 low read during capture returns old");
      step(0, 10'h000, 1, 0, "R8 new data kept ready set");
      // both strobes: low byte wins
      step(1, 10'h3FF, 0, 0, "R9 idle");
      step(0, 10'h000, 1, 1, "R9 both strobes give low byte");
      step(0, 10'h000, 0, 0, "R9 idle zero");
      repeat (4) @(negedge clk);
      cap_valid = 0; rd_lo = 0; rd_hi = 0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule